// File: doc/BRIEF.md
# Programmable Tap-Select Binary Timer

A synchronous binary timer built around a 16-stage counter that advances on enabled rising clock edges. A two-bit select picks one of four counter stages (8, 10, 13 or 16) as the output tap. A mode input chooses between two behaviours. In free-running mode the tap is a square wave at the clock rate divided by 2^N. In one-shot mode the output changes level once, after 2^(N-1) counts, and then holds. A polarity input gives either the true level or its inverse.

The counter and the one-shot latch are cleared by an active-high master reset. They are also cleared by a power-on pulse, unless the auto-reset path is disabled. Counting starts only after one of these clears has happened. An oscillator-enable output goes low whenever a clear is active, so an external clock source can be stopped during reset. A new master reset pulse restarts a one-shot from zero, so the timer is retriggerable.

Top module: `ptimer_top`

## Requirements
- R1: After the synchronous active-low `rst_n`, the counter is zero, the one-shot latch is clear and the timer is not armed. With `inv`=0 the output is 0 and `osc_en` is 1 while no clear is active.
- R2: The select code maps to a stage as follows: `sel`=0 gives stage 13, `sel`=1 gives stage 10, `sel`=2 gives stage 8 and `sel`=3 gives stage 16. Stage N is counter bit N-1.
- R3: With `mode`=1, after k enabled counts from a clear, the output equals bit N-1 of k. It first rises at count 2^(N-1) and has a period of 2^N counts.
- R4: With `mode`=0 and `inv`=0, the output is 0 for counts below 2^(N-1) and becomes 1 at exactly count 2^(N-1).
- R5: With `mode`=0, once the output has fired, the counter stops. The output holds through any number of further enabled clocks, including clocks past the point where the stage would have wrapped.
- R6: `inv`=1 inverts the output in both modes. In one-shot mode the output is then high from the clear until the count completes.
- R7: A high `mreset` clears the counter and the one-shot latch on the next edge. A new pulse during a run restarts the timing from zero.
- R8: While `count_en` is 0, the counter holds its value.
- R9: With `auto_dis`=0, a `por` pulse clears and arms the timer, and counting then begins.
- R10: With `auto_dis`=1, `por` has no effect. No counting happens until a `mreset` pulse has been applied and released.
- R11: `osc_en` is 0 while `mreset` is high, and while `por` is high with `auto_dis`=0.
- R12: In one-shot mode, after the output has fired, setting `mode` to 1 makes the output follow the selected stage again, and counting resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock; the counter advances on rising edges |
| rst_n | input | 1 | Synchronous active-low block reset |
| count_en | input | 1 | Count qualifier; the counter advances only while this is 1 |
| mreset | input | 1 | Active-high master reset; clears and arms the timer |
| por | input | 1 | Power-on pulse; acts as a clear when auto_dis is 0 |
| auto_dis | input | 1 | 1 disables the power-on clear path |
| sel | input | 2 | Tap select code (0:13, 1:10, 2:8, 3:16) |
| mode | input | 1 | 1 = free-running divider, 0 = one-shot |
| inv | input | 1 | 1 = inverted output polarity |
| tmr_out | output | 1 | Timer output |
| osc_en | output | 1 | Oscillator enable; low while a clear is active |

## Verification
A wrong counter value always shows up as an output edge at the wrong count. The bench therefore compares the output on every clock of each run against the count at which the selected stage should toggle, so an off-by-one in the counter or the select decode is caught at the first expected edge. A one-shot that fails to freeze, or a latch that is cleared, shows as a fall within one stage period of the firing point. An arming fault appears as counting before the first clear, or as no counting after it. Both are seen by the end of the first 2^(N-1) counts.

// File: rtl/ptimer_pkg.sv
// Package: shared types for the programmable tap-select timer.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package ptimer_pkg;

    // Output behaviour selected by the mode input.
    typedef enum logic {
        PT_ONESHOT = 1'b0,
        PT_FREERUN = 1'b1
    } pt_mode_e;

    // Number of selectable output taps.
    localparam int PT_NTAPS = 4;

endpackage

// File: rtl/ptimer_ctrl.sv
// Module: ptimer_ctrl
// Builds the clear request from the master reset and the gated power-on
// path. Keeps the "armed" flag that allows counting after the first clear.
// Drives the oscillator enable.
// Assumes: all inputs are synchronous to clk; rst_n is synchronous, active low.
module ptimer_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic mreset,
    input  logic por,
    input  logic auto_dis,
    output logic clr,
    output logic armed,
    output logic osc_en
);

    logic armed_q;

    // Clear request: master reset, or power-on pulse when auto path enabled.
    always_comb begin
        clr    = mreset | (por & ~auto_dis);
        osc_en = ~clr;
    end

    // Arming flag: set by any clear, dropped only by the block reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (clr) begin
            armed_q <= 1'b1;
        end
    end

    assign armed = armed_q;

endmodule

// File: rtl/ptimer_counter.sv
// Module: ptimer_counter
// W-bit synchronous binary counter with synchronous clear and advance enable.
// It also brings out the four tap bits, each stage chosen by a parameter.
// Assumes: each STAGEn lies in 1..W; clr has priority over adv.
module ptimer_counter #(
    parameter int W      = 16,
    parameter int STAGE0 = 13,
    parameter int STAGE1 = 10,
    parameter int STAGE2 = 8,
    parameter int STAGE3 = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           clr,
    input  logic                           adv,
    output logic [W-1:0]                   cnt,
    output logic [ptimer_pkg::PT_NTAPS-1:0] taps
);

    localparam int NT = ptimer_pkg::PT_NTAPS;
    localparam int STAGES [NT] = '{STAGE0, STAGE1, STAGE2, STAGE3};

    logic [W-1:0] cnt_q;

    // Counter state: reset/clear to zero, else step by one when advancing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (adv) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Tap extraction: stage N of the chain is counter bit N-1.
    for (genvar i = 0; i < NT; i++) begin : g_tap
        assign taps[i] = cnt_q[STAGES[i]-1];
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/ptimer_tap.sv
// Module: ptimer_tap
// Selects one tap, applies the free-run or one-shot behaviour and the
// output polarity. Holds the one-shot latch and requests a counter freeze
// once the shot has fired.
// Assumes: taps come straight from counter registers; clr is synchronous.
module ptimer_tap (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            clr,
    input  logic [ptimer_pkg::PT_NTAPS-1:0] taps,
    input  logic [1:0]                      sel,
    input  logic                            mode,
    input  logic                            inv,
    output logic                            done,
    output logic                            freeze,
    output logic                            out
);

    import ptimer_pkg::*;

    pt_mode_e mode_e;
    logic     tap_bit;
    logic     shot_q;
    logic     level;

    // Decode mode and pick the selected stage.
    always_comb begin
        mode_e  = pt_mode_e'(mode);
        tap_bit = taps[sel];
    end

    // One-shot latch: cleared by any clear, set when the tap fires in one-shot mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shot_q <= 1'b0;
        end else if (clr) begin
            shot_q <= 1'b0;
        end else if (mode_e == PT_ONESHOT && tap_bit) begin
            shot_q <= 1'b1;
        end
    end

    // Output level, polarity and freeze request.
    always_comb begin
        done   = shot_q | tap_bit;
        level  = (mode_e == PT_FREERUN) ? tap_bit : done;
        out    = level ^ inv;
        freeze = (mode_e == PT_ONESHOT) & done;
    end

endmodule

// File: rtl/ptimer_top.sv
// Module: ptimer_top
// Programmable tap-select binary timer: clear/arm control, W-bit counter
// and tap/mode/polarity output stage.
// Assumes: synchronous inputs; rst_n is a synchronous active-low block reset.
module ptimer_top #(
    parameter int W      = 16,
    parameter int STAGE0 = 13,
    parameter int STAGE1 = 10,
    parameter int STAGE2 = 8,
    parameter int STAGE3 = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       count_en,
    input  logic       mreset,
    input  logic       por,
    input  logic       auto_dis,
    input  logic [1:0] sel,
    input  logic       mode,
    input  logic       inv,
    output logic       tmr_out,
    output logic       osc_en
);

    localparam int NT = ptimer_pkg::PT_NTAPS;

    logic          clr_w;
    logic          armed_w;
    logic          adv_w;
    logic          freeze_w;
    logic          done_w;
    logic [W-1:0]  cnt_w;
    logic [NT-1:0] taps_w;

    ptimer_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .mreset   (mreset),
        .por      (por),
        .auto_dis (auto_dis),
        .clr      (clr_w),
        .armed    (armed_w),
        .osc_en   (osc_en)
    );

    // Advance qualifier: armed, not clearing, enabled, not frozen by a fired shot.
    always_comb begin
        adv_w = armed_w & ~clr_w & count_en & ~freeze_w;
    end

    ptimer_counter #(
        .W      (W),
        .STAGE0 (STAGE0),
        .STAGE1 (STAGE1),
        .STAGE2 (STAGE2),
        .STAGE3 (STAGE3)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_w),
        .adv   (adv_w),
        .cnt   (cnt_w),
        .taps  (taps_w)
    );

    ptimer_tap u_tap (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr_w),
        .taps   (taps_w),
        .sel    (sel),
        .mode   (mode),
        .inv    (inv),
        .done   (done_w),
        .freeze (freeze_w),
        .out    (tmr_out)
    );

endmodule

// File: rtl/ptimer_chk.sv
// Module: ptimer_chk
// Temporal properties of the timer, attached to ptimer_top by bind.
// Assumes: the bound signals are the top's internal clear, arm, count and
// one-shot status nets.
module ptimer_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         clr,
    input logic         armed,
    input logic         count_en,
    input logic         mode,
    input logic         done,
    input logic [W-1:0] cnt
);

    // R7
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));

    // R8
    en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!count_en && !clr) |=> $stable(cnt));

    // R3
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));

    // R5
    shot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode && done && !clr) |=> done);

    // R10
    unarmed_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !clr) |=> (cnt == '0));

endmodule

bind ptimer_top ptimer_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr_w),
    .armed    (armed_w),
    .count_en (count_en),
    .mode     (mode),
    .done     (done_w),
    .cnt      (cnt_w)
);

// File: tb/tb_ptimer_top.sv
`timescale 1ns/1ps
module tb_ptimer_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       count_en = 1'b0;
    logic       mreset = 1'b0;
    logic       por = 1'b0;
    logic       auto_dis = 1'b0;
    logic [1:0] sel = 2'd0;
    logic       mode = 1'b1;
    logic       inv = 1'b0;
    logic       tmr_out;
    logic       osc_en;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    ptimer_top dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .count_en (count_en),
        .mreset   (mreset),
        .por      (por),
        .auto_dis (auto_dis),
        .sel      (sel),
        .mode     (mode),
        .inv      (inv),
        .tmr_out  (tmr_out),
        .osc_en   (osc_en)
    );

    function automatic int stage_of(input logic [1:0] c);
        case (c)
            2'd0:    return 13;
            2'd1:    return 10;
            2'd2:    return 8;
            default: return 16;
        endcase
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    // Master reset pulse of one edge; afterwards the counter is at zero and counting is enabled.
    task automatic pulse_mreset();
        @(negedge clk);
        mreset = 1'b1;
        #1;
        chk("R11 osc_en during mreset", osc_en, 1'b0);
        @(negedge clk);
        mreset   = 1'b0;
        count_en = 1'b1;
        #1;
    endtask

    // R1: state straight after block reset.
    task automatic scen_reset();
        mode = 1'b1; inv = 1'b0; sel = 2'd2; count_en = 1'b1;
        auto_dis = 1'b0; por = 1'b0; mreset = 1'b0;
        do_reset();
        chk("R1 out after reset", tmr_out, 1'b0);
        chk("R1 osc_en after reset", osc_en, 1'b1);
    endtask

    // R10: power-on pulse ignored when auto path disabled; mreset needed.
    task automatic scen_noauto();
        auto_dis = 1'b1; mode = 1'b1; inv = 1'b0; sel = 2'd2; count_en = 1'b1;
        do_reset();
        @(negedge clk);
        por = 1'b1;
        #1;
        chk("R10 osc_en with por ignored", osc_en, 1'b1);
        @(negedge clk);
        por = 1'b0;
        for (int k = 1; k <= 300; k++) begin
            @(negedge clk);
            chk("R10 no count before mreset", tmr_out, 1'b0);
        end
        pulse_mreset();
        for (int k = 1; k <= 128; k++) begin
            @(negedge clk);
            if (k >= 127) chk("R10 counts after mreset", tmr_out, (k >= 128));
        end
        auto_dis = 1'b0;
    endtask

    // R9 / R11: power-on clear arms the timer when auto path enabled.
    task automatic scen_auto();
        auto_dis = 1'b0; mode = 1'b0; inv = 1'b0; sel = 2'd2; count_en = 1'b1;
        do_reset();
        @(negedge clk);
        por = 1'b1;
        #1;
        chk("R11 osc_en during por", osc_en, 1'b0);
        repeat (2) @(negedge clk);
        por = 1'b0;
        #1;
        chk("R11 osc_en after por", osc_en, 1'b1);
        for (int k = 1; k <= 128; k++) begin
            @(negedge clk);
            if (k >= 127) chk("R9 auto clear arms counting", tmr_out, (k >= 128));
        end
    endtask

    // R2 / R3 / R6: free-running divider, compared on every count.
    task automatic scen_free(input logic [1:0] code, input logic pol, input int edges);
        int n;
        n = stage_of(code);
        mode = 1'b1; inv = pol; sel = code;
        pulse_mreset();
        chk(pol ? "R6 free start" : "R3 free start", tmr_out, pol);
        for (int k = 1; k <= edges; k++) begin
            @(negedge clk);
            chk(pol ? "R6,R2 free inverted" : "R2,R3 free divider",
                tmr_out, (((k >> (n - 1)) & 1) != 0) ^ pol);
        end
    endtask

    // R4 / R5 / R6: one-shot edge count and hold past wrap point.
    task automatic scen_shot(input logic [1:0] code, input logic pol, input int extra);
        int half;
        half = 1 << (stage_of(code) - 1);
        mode = 1'b0; inv = pol; sel = code;
        pulse_mreset();
        chk("R6 shot level at start", tmr_out, pol);
        for (int k = 1; k <= half + extra; k++) begin
            @(negedge clk);
            if (k <= half)
                chk(pol ? "R6 shot inverted" : "R4 shot edge", tmr_out, (k >= half) ^ pol);
            else
                chk("R5 shot hold", tmr_out, ~pol);
        end
    endtask

    // R8: counting pauses while count_en is low.
    task automatic scen_enable();
        mode = 1'b1; inv = 1'b0; sel = 2'd2;
        pulse_mreset();
        repeat (100) @(negedge clk);
        count_en = 1'b0;
        for (int k = 1; k <= 60; k++) begin
            @(negedge clk);
            chk("R8 paused", tmr_out, 1'b0);
        end
        count_en = 1'b1;
        for (int k = 1; k <= 28; k++) begin
            @(negedge clk);
            if (k >= 27) chk("R8 resumes at held count", tmr_out, (k >= 28));
        end
    endtask

    // R7: mreset during a run restarts one-shot timing from zero.
    task automatic scen_retrigger();
        mode = 1'b0; inv = 1'b0; sel = 2'd2;
        pulse_mreset();
        repeat (100) @(negedge clk);
        pulse_mreset();
        chk("R7 cleared by retrigger", tmr_out, 1'b0);
        for (int k = 1; k <= 128; k++) begin
            @(negedge clk);
            if (k >= 127) chk("R7 retrigger full interval", tmr_out, (k >= 128));
        end
    endtask

    // R12: after firing, mode 1 follows the stage and counting resumes.
    task automatic scen_switch();
        mode = 1'b0; inv = 1'b0; sel = 2'd2;
        pulse_mreset();
        repeat (128) @(negedge clk);
        chk("R4 fired before switch", tmr_out, 1'b1);
        mode = 1'b1;
        for (int j = 1; j <= 140; j++) begin
            @(negedge clk);
            chk("R12 follows stage after switch", tmr_out, (((128 + j) >> 7) & 1) != 0);
        end
        mode = 1'b0;
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin : main
        scen_reset();
        scen_noauto();
        scen_auto();
        scen_free(2'd2, 1'b0, 520);
        scen_free(2'd2, 1'b1, 520);
        scen_free(2'd1, 1'b0, 2100);
        scen_free(2'd0, 1'b0, 8200);
        scen_free(2'd3, 1'b0, 32770);
        scen_shot(2'd2, 1'b0, 400);
        scen_shot(2'd2, 1'b1, 400);
        scen_shot(2'd1, 1'b0, 600);
        scen_shot(2'd0, 1'b1, 100);
        scen_shot(2'd3, 1'b0, 20);
        scen_enable();
        scen_retrigger();
        scen_switch();
        finished = 1;
        summary();
        $finish;
    end

endmodule